// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 256K words by 4 bits. The RAM has an 18-bit address and one shared bidirectional data bus. The host issues one request at a time over a request/ready handshake that carries an address, write data and a write flag. Each finished read returns the captured word with a one-cycle valid pulse.

On the memory side the controller drives active-low chip select, write enable and output enable, and a data bus split into an output value, an output-enable control and an input value. The pin-level tri-state buffer sits outside the block. Every timing minimum of the RAM is given as a parameter in clock cycles, found by rounding the nanosecond figure up at the clock period in use. Output enable stays high for the whole of every write, so the shorter write pulse applies. The controller turns on its own drivers only after the RAM has released the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, ready is 1, chip select, write enable and output enable are all high, the data drive enable is 0 and read-valid is 0.
- R2: A request is taken on a rising clock edge where request and ready are both 1. Ready is 0 from that edge until the cycle ends. It returns ACC_CYC+GAP_CYC edges after acceptance for a read and TURN_CYC+WP_CYC+GAP_CYC edges after acceptance for a write.
- R3: For a read, chip select and output enable are low and write enable is high for exactly ACC_CYC cycles after acceptance. The data drive enable stays 0 throughout.
- R4: The read word is sampled from the bus input on the edge that ends the access window. Read-valid is 1 for exactly one cycle, ACC_CYC+1 cycles after acceptance, with that word on the read-data output.
- R5: For a write, output enable stays high throughout. Chip select is low with write enable high for TURN_CYC cycles. Then write enable is low for exactly WP_CYC cycles, with the write data driven and the drive enable at 1.
- R6: The data drive enable is never 1 while output enable is low, and it is 1 in every cycle where write enable is low.
- R7: After every operation, chip select stays high for at least GAP_CYC cycles before another operation begins, even when request is held high.
- R8: The memory address stays stable while chip select is low and equals the address presented at acceptance.
- R9: Address, write data, write flag and request are ignored while ready is 0. Changing them during an operation does not affect that operation, and no second operation starts until ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Host request |
| ready_o | output | 1 | Controller can accept a request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Host word address |
| wdata_i | input | 4 | Host write data |
| rvalid_o | output | 1 | One-cycle read completion pulse |
| rdata_o | output | 4 | Captured read word |
| sram_addr_o | output | 18 | Memory address |
| sram_cs_n_o | output | 1 | Memory chip select, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_dq_o | output | 4 | Value driven onto the data bus |
| sram_dq_oe_o | output | 1 | Controller drives the data bus when 1 |
| sram_dq_i | input | 4 | Value seen on the data bus |

## Verification
After each acceptance edge the bench counts falling edges. It expects the read strobes on falling edges 1 to ACC_CYC, read-valid and the data on falling edge ACC_CYC+1, the turnaround and write pulse on falling edges 1 to TURN_CYC and TURN_CYC+1 to TURN_CYC+WP_CYC, and ready again only once the gap has passed. All pins are sampled on the falling edge, half a cycle away from the edge that updates them, and each phase is checked on exactly the falling edge its cycle count predicts. A model memory on the bus flags contention in any cycle, and random traffic is checked against a separate reference array.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int ACC_CYC  = 2,
  parameter int TURN_CYC = 1,
  parameter int WP_CYC   = 1,
  parameter int GAP_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int MAX_A = (ACC_CYC > TURN_CYC) ? ACC_CYC : TURN_CYC;
  localparam int MAX_B = (WP_CYC > GAP_CYC) ? WP_CYC : GAP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WPULSE, S_GAP} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cnt_done;

  assign cnt_done     = (cnt == '0);
  assign ready_o      = (state == S_IDLE);
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_cs_n_o  = !(state == S_RD || state == S_TURN || state == S_WPULSE);
  assign sram_oe_n_o  = (state != S_RD);
  assign sram_we_n_o  = (state != S_WPULSE);
  assign sram_dq_oe_o = (state == S_WPULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      case (state)
        S_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          if (we_i) begin
            state <= S_TURN;
            cnt   <= CNT_W'(TURN_CYC - 1);
          end else begin
            state <= S_RD;
            cnt   <= CNT_W'(ACC_CYC - 1);
          end
        end
        S_RD: if (cnt_done) begin
          rdata_o  <= sram_dq_i;
          rvalid_o <= 1'b1;
          state    <= S_GAP;
          cnt      <= CNT_W'(GAP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt_done) begin
          state <= S_WPULSE;
          cnt   <= CNT_W'(WP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WPULSE: if (cnt_done) begin
          state <= S_GAP;
          cnt   <= CNT_W'(GAP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt_done) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Run-length counters used only by the checks below
  logic [CNT_W:0] we_len, hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_len <= '0;
      hi_len <= '0;
    end else begin
      we_len <= sram_we_n_o ? '0 : we_len + 1'b1;
      hi_len <= !sram_cs_n_o ? '0 : ((hi_len == '1) ? hi_len : hi_len + 1'b1);
    end
  end

  p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe_o |-> sram_oe_n_o);
  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n_o |-> sram_dq_oe_o);
  p_oe_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n_o |-> (sram_oe_n_o && !sram_cs_n_o));
  p_drive_after_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe_o) |-> ($past(sram_oe_n_o) && !$past(sram_cs_n_o)));
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n_o) |-> (we_len == (CNT_W+1)'(WP_CYC)));
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n_o |-> !ready_o);
  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n_o && $past(!sram_cs_n_o)) |-> $stable(sram_addr_o));
  p_gap_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sram_cs_n_o) && $past(rst_n)) |-> (hi_len >= (CNT_W+1)'(GAP_CYC)));

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
  localparam int AW = 18, DW = 4, ACC = 2, TURN = 1, WP = 1, GAP = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic ready_o, rvalid_o, cs_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata_o, dq_o, dq_i;
  logic [AW-1:0] sram_addr;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .TURN_CYC(TURN),
               .WP_CYC(WP), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_o(ready_o), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .sram_addr_o(sram_addr), .sram_cs_n_o(cs_n), .sram_we_n_o(we_n),
    .sram_oe_n_o(oe_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i));

  // Bus-level memory model and bench reference array
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [DW-1:0] refm [logic [AW-1:0]];

  function automatic logic [DW-1:0] ref_rd(logic [AW-1:0] a);
    return refm.exists(a) ? refm[a] : '0;
  endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", rq, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && !cs_n && we_n && !oe_n)
        check(1'b0, "R6 bus contention", 1, 0);
      if (!cs_n && !we_n) begin
        if (!dq_oe) check(1'b0, "R6 write without drive", 0, 1);
        mem[sram_addr] = dq_o;
      end
    end
    dq_i <= (!cs_n && we_n && !oe_n) ? (mem.exists(sram_addr) ? mem[sram_addr] : '0) : 4'h0;
  end

  task automatic wait_ready();
    for (int t = 0; t < 50 && !ready_o; t++) @(negedge clk);
    check(ready_o, "R2 ready timeout", ready_o, 1);
  endtask

  // hold: keep request high and disturb the inputs while busy (R9)
  task automatic run_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit hold);
    logic [DW-1:0] exp;
    int total;
    wait_ready();
    exp = ref_rd(a);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(posedge clk);
    total = w ? (TURN + WP + GAP) : (ACC + GAP);
    for (int i = 1; i <= total + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (hold) begin
          addr_i = a ^ 18'h00F0F; we_i = ~w; wdata_i = ~d;
        end else req_i = 1'b0;
      end
      if (i <= total)
        check(!ready_o, "R2 ready low while busy", ready_o, 0);
      else begin
        check(ready_o, "R2 ready return cycle", ready_o, 1);
        req_i = 1'b0;
      end
      if (i <= total) begin
        if (!w && i <= ACC) begin
          check(!cs_n && !oe_n && we_n && !dq_oe, "R3 read strobes",
                {cs_n, oe_n, we_n, dq_oe}, 4'b0010);
          check(sram_addr == a, "R8 read address", sram_addr, a);
          check(!rvalid_o, "R4 no early valid", rvalid_o, 0);
        end else if (w && i <= TURN) begin
          check(!cs_n && oe_n && we_n && !dq_oe, "R5 turnaround",
                {cs_n, oe_n, we_n, dq_oe}, 4'b0110);
        end else if (w && i <= TURN + WP) begin
          check(!cs_n && oe_n && !we_n && dq_oe, "R5 write pulse",
                {cs_n, oe_n, we_n, dq_oe}, 4'b0101);
          check(sram_addr == a && dq_o == d, "R8 write addr/data",
                {sram_addr, dq_o}, {a, d});
        end else begin
          check(cs_n && we_n && oe_n, "R7 gap strobes", {cs_n, we_n, oe_n}, 3'b111);
        end
        if (!w && i == ACC + 1) begin
          check(rvalid_o, "R4 valid pulse", rvalid_o, 1);
          check(rdata_o == exp, "R4 read data", rdata_o, exp);
        end else if (!w && i > ACC + 1)
          check(!rvalid_o, "R4 single pulse", rvalid_o, 0);
      end
    end
    if (w) refm[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    check(ready_o && cs_n && we_n && oe_n && !dq_oe && !rvalid_o, "R1 reset state",
          {ready_o, cs_n, we_n, oe_n, dq_oe, rvalid_o}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o && cs_n && we_n && oe_n && !dq_oe && !rvalid_o, "R1 after reset",
          {ready_o, cs_n, we_n, oe_n, dq_oe, rvalid_o}, 6'b111100);
    // directed corners
    run_op(1'b1, 18'h00000, 4'hA, 1'b0);
    run_op(1'b1, 18'h3FFFF, 4'h5, 1'b0);
    run_op(1'b0, 18'h00000, 4'h0, 1'b0);
    run_op(1'b0, 18'h3FFFF, 4'h0, 1'b0);
    run_op(1'b0, 18'h12345, 4'h0, 1'b0);
    // R9: inputs changed during a write with request held high
    run_op(1'b1, 18'h00200, 4'hC, 1'b1);
    run_op(1'b0, 18'h00200 ^ 18'h00F0F, 4'h0, 1'b0);
    run_op(1'b0, 18'h00200, 4'h0, 1'b1);
    run_op(1'b0, 18'h00200, 4'h0, 1'b0);
    // constrained random traffic over a small window plus the ends
    for (int n = 0; n < 80; n++) begin
      case ($urandom % 4)
        0: a = 18'h3FFFF - 18'($urandom % 4);
        1: a = 18'($urandom % 4);
        default: a = 18'h01000 + 18'($urandom % 16);
      endcase
      run_op(1'($urandom % 2), a, 4'($urandom), 1'($urandom % 4 == 0));
    end
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule